// File: doc/BRIEF.md
# Register soft-lock protection unit

This unit sits in front of a small bank of 32-bit peripheral registers and decides, byte by byte, whether a bus write may reach them. Every register word carries four lock bits, one per byte lane. A build-time granularity setting for each lane decides how a single lock-bit write spreads over the word: one control bit can guard the whole word, half of it, a single byte, or nothing. A write to a locked byte is dropped and the bus sees an error, while unlocked bytes of the same write still go through.

Software reaches four address regions that share one word index. These are the plain data window, a second data window that locks the written bytes once the write is done, the lock-bit registers, and a control word holding a sticky hard-lock bit. Once the hard-lock bit is set, no lock bit can change again until reset. The peripheral side sees a filtered write strobe, byte enables and data in the same cycle as the request. The bus response (valid, error, read data) comes one cycle later.

Top module: `reg_softlock_unit`

## Requirements
- R1: After reset all lock bits and the hard-lock bit read 0, and `rsp_valid` is 0 while reset is applied.
- R2: A write to the lock region (address bits [IDX_W+1:IDX_W] = 2) carries lock values in `bus_wdata[3:0]` and per-lane enables in `bus_wdata[7:4]`. A lane at 8-bit granularity takes its own value only when its own enable is set, and otherwise keeps its value.
- R3: In a word whose lanes are all set to 32-bit granularity, the enable and value of lane 0 update all four lock bits. The enables and values of lanes 1 to 3 have no effect.
- R4: For a lane pair at 16-bit granularity (lanes 0/1 or 2/3), the enable and value of the lower lane update both lock bits. The enable and value of the upper lane have no effect.
- R5: A lane at unprotected granularity always has lock bit 0, whatever is written. Granularity is 2 bits per lane, lane 0 in the lowest bits: 00 unprotected, 01 8-bit, 10 16-bit, 11 32-bit.
- R6: A read of the lock region returns the word's four lock bits in bits 3:0 and zero in all other bits, so the enable bits read as 0.
- R7: A write to the data window (region 0) passes only the enabled bytes whose lock bit is clear to `prf_be`, and `prf_wr` is high only if at least one byte passes. The response flags an error if any enabled byte was locked.
- R8: A write to the mirror window (region 1) filters data as in R7. It then applies a lock write with value 1 and with enables equal to `bus_be`, using the granularity rules of R3 to R5, unless hard lock is set.
- R9: Writing 1 to bit 0 of the control region (region 3) sets hard lock, and writing 0 does not clear it. While hard lock is set, lock-region writes change nothing and return an error, and mirror-window writes leave the lock bits unchanged.
- R10: Reads never return an error. Reads of the data and mirror windows both return `prf_rdata` for the indexed word, and a control read returns hard lock in bit 0.
- R11: Each request gets `rsp_valid` exactly one cycle later, and a cycle without a request gives no response in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | IDX_W+2 | Region in the top two bits, word index below |
| bus_be | input | 4 | Byte enables of a data write |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Transfer error |
| rsp_rdata | output | 32 | Read data |
| prf_wr | output | 1 | Filtered write strobe to the register bank |
| prf_idx | output | IDX_W | Word index of the current request |
| prf_be | output | 4 | Byte lanes allowed through |
| prf_wdata | output | 32 | Write data to the register bank |
| prf_rdata | input | 32 | Read data of word `prf_idx` from the register bank |

## Verification
A wrong lock bit becomes visible on the very request that touches its byte. In that cycle `prf_be` loses or gains a lane, and in the next cycle `rsp_err` shows the mismatch. It can also be read back from the lock region with a one-cycle delay. A granularity or mirroring mistake stays hidden until a lane's neighbour is written or read, so the bench reads the lock word back after every lock write, including writes whose enables should not count. A stuck or lost hard-lock bit shows up on the next lock-region write as a missing or unexpected error.

// File: rtl/softlock_pkg.sv
package softlock_pkg;

  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_MIRR = 2'd1,
    RGN_LOCK = 2'd2,
    RGN_CTRL = 2'd3
  } region_e;

  localparam int LANES = 4;

  // Granularity code per lane: 00 none, 01 byte, 10 half, 11 word.
  function automatic logic [LANES-1:0] lock_merge(
    input logic [2*LANES-1:0] gcfg,
    input logic [LANES-1:0]   cur,
    input logic [LANES-1:0]   val,
    input logic [LANES-1:0]   wen
  );
    logic [LANES-1:0] res;
    for (int l = 0; l < LANES; l++) begin
      logic [1:0] g;
      int         src;
      g = gcfg[2*l +: 2];
      case (g)
        2'b11:   src = 0;
        2'b10:   src = l & 2;
        default: src = l;
      endcase
      if (g == 2'b00)    res[l] = 1'b0;
      else if (wen[src]) res[l] = val[src];
      else               res[l] = cur[l];
    end
    return res;
  endfunction

endpackage

// File: rtl/slk_lock_word.sv
module slk_lock_word
  import softlock_pkg::*;
#(
  parameter logic [2*LANES-1:0] GCFG = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [LANES-1:0] upd_val,
  input  logic [LANES-1:0] upd_wen,
  output logic [LANES-1:0] lock_q
);

  logic [LANES-1:0] lock_d;

  always_comb begin
    lock_d = lock_merge(GCFG, lock_q, upd_val, upd_wen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= '0;
    else if (upd_en) lock_q <= lock_d;
  end

endmodule

// File: rtl/slk_access.sv
module slk_access
  import softlock_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int NUM_WORDS = 4
) (
  input  logic                     bus_req,
  input  logic                     bus_wr,
  input  logic [IDX_W+1:0]         bus_addr,
  input  logic [LANES-1:0]         bus_be,
  input  logic [7:0]               wdata_lo,
  input  logic [LANES*NUM_WORDS-1:0] lock_flat,
  input  logic                     hard_q,
  input  logic [31:0]              prf_rdata,
  output logic                     prf_wr,
  output logic [IDX_W-1:0]         prf_idx,
  output logic [LANES-1:0]         prf_be,
  output logic [NUM_WORDS-1:0]     upd_en,
  output logic [LANES-1:0]         upd_val,
  output logic [LANES-1:0]         upd_wen,
  output logic                     hard_set,
  output logic                     err_d,
  output logic [31:0]              rdata_d
);

  region_e          region;
  logic [LANES-1:0] cur_lock;
  logic [LANES-1:0] blocked;
  logic             lock_go;

  assign region   = region_e'(bus_addr[IDX_W +: 2]);
  assign prf_idx  = bus_addr[IDX_W-1:0];
  assign cur_lock = lock_flat[LANES*prf_idx +: LANES];
  assign blocked  = bus_be & cur_lock;

  always_comb begin
    prf_be   = '0;
    err_d    = 1'b0;
    lock_go  = 1'b0;
    upd_val  = '0;
    upd_wen  = '0;
    hard_set = 1'b0;
    rdata_d  = '0;
    if (bus_req && bus_wr) begin
      case (region)
        RGN_DATA: begin
          prf_be = bus_be & ~cur_lock;
          err_d  = |blocked;
        end
        RGN_MIRR: begin
          prf_be  = bus_be & ~cur_lock;
          err_d   = |blocked;
          lock_go = !hard_q;
          upd_val = '1;
          upd_wen = bus_be;
        end
        RGN_LOCK: begin
          err_d   = hard_q;
          lock_go = !hard_q;
          upd_val = wdata_lo[3:0];
          upd_wen = wdata_lo[7:4];
        end
        RGN_CTRL: hard_set = wdata_lo[0];
        default: ;
      endcase
    end else if (bus_req) begin
      case (region)
        RGN_DATA, RGN_MIRR: rdata_d = prf_rdata;
        RGN_LOCK:           rdata_d = {{(32-LANES){1'b0}}, cur_lock};
        RGN_CTRL:           rdata_d = {31'b0, hard_q};
        default: ;
      endcase
    end
  end

  assign prf_wr = |prf_be;
  assign upd_en = lock_go ? (NUM_WORDS'(1) << prf_idx) : '0;

endmodule

// File: rtl/reg_softlock_unit.sv
module reg_softlock_unit
  import softlock_pkg::*;
#(
  parameter int                       IDX_W = 2,
  parameter logic [8*(1<<IDX_W)-1:0]  GRAN  = 32'hAA55_4AFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [IDX_W+1:0]   bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic               prf_wr,
  output logic [IDX_W-1:0]   prf_idx,
  output logic [3:0]         prf_be,
  output logic [31:0]        prf_wdata,
  input  logic [31:0]        prf_rdata
);

  localparam int NUM_WORDS = 1 << IDX_W;

  logic [1:0]                   rst_pipe;
  logic                         rst_sync_n;
  logic [LANES*NUM_WORDS-1:0]   lock_flat;
  logic                         hard_q;
  logic                         hard_d;
  logic [NUM_WORDS-1:0]         upd_en;
  logic [LANES-1:0]             upd_val;
  logic [LANES-1:0]             upd_wen;
  logic                         hard_set;
  logic                         err_d;
  logic [31:0]                  rdata_d;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  slk_access #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) u_access (
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .wdata_lo  (bus_wdata[7:0]),
    .lock_flat (lock_flat),
    .hard_q    (hard_q),
    .prf_rdata (prf_rdata),
    .prf_wr    (prf_wr),
    .prf_idx   (prf_idx),
    .prf_be    (prf_be),
    .upd_en    (upd_en),
    .upd_val   (upd_val),
    .upd_wen   (upd_wen),
    .hard_set  (hard_set),
    .err_d     (err_d),
    .rdata_d   (rdata_d)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    slk_lock_word #(.GCFG(GRAN[8*w +: 8])) u_word (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .upd_en  (upd_en[w]),
      .upd_val (upd_val),
      .upd_wen (upd_wen),
      .lock_q  (lock_flat[LANES*w +: LANES])
    );
  end

  assign prf_wdata = bus_wdata;

  always_comb begin
    hard_d = hard_q | hard_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   hard_q <= 1'b0;
    else if (hard_set) hard_q <= hard_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_req;
      if (bus_req) begin
        rsp_err   <= err_d;
        rsp_rdata <= rdata_d;
      end
    end
  end

endmodule

// File: rtl/slk_checker.sv
module slk_checker #(
  parameter int                      IDX_W = 2,
  parameter logic [8*(1<<IDX_W)-1:0] GRAN  = 32'hAA55_4AFF
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        bus_req,
  input logic                        bus_wr,
  input logic [1:0]                  region,
  input logic [3:0]                  wen_bits,
  input logic                        prf_wr,
  input logic [IDX_W-1:0]            prf_idx,
  input logic [3:0]                  prf_be,
  input logic                        rsp_valid,
  input logic                        rsp_err,
  input logic [4*(1<<IDX_W)-1:0]     lock_flat,
  input logic                        hard_q
);

  localparam int NW = 1 << IDX_W;

  function automatic logic [4*NW-1:0] unprot_mask(input logic [8*NW-1:0] g);
    logic [4*NW-1:0] m;
    for (int i = 0; i < 4*NW; i++) m[i] = (g[2*i +: 2] == 2'b00);
    return m;
  endfunction

  localparam logic [4*NW-1:0] UNPROT = unprot_mask(GRAN);

  logic [3:0] cur_lock;
  assign cur_lock = lock_flat[4*prf_idx +: 4];

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_req |=> rsp_valid);
  // R11
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_req |=> !rsp_valid);
  // R7
  locked_byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prf_wr |-> ((prf_be & cur_lock) == 4'b0));
  // R5
  unprot_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((lock_flat & UNPROT) == '0));
  // R9
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hard_q |=> hard_q);
  // R9
  hard_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hard_q |=> $stable(lock_flat));
  // R2
  no_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_wr && region == 2'd2 && wen_bits == 4'd0) |=> $stable(lock_flat));
  // R10
  read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && !bus_wr) |=> !rsp_err);

endmodule

bind reg_softlock_unit slk_checker #(.IDX_W(IDX_W), .GRAN(GRAN)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .region     (bus_addr[IDX_W +: 2]),
  .wen_bits   (bus_wdata[7:4]),
  .prf_wr     (prf_wr),
  .prf_idx    (prf_idx),
  .prf_be     (prf_be),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .lock_flat  (lock_flat),
  .hard_q     (hard_q)
);

// File: tb/reg_softlock_unit_tb_top.sv
`timescale 1ns/1ps
module reg_softlock_unit_tb_top;

  localparam int          IDX_W = 2;
  localparam logic [31:0] CFG   = 32'hAA55_4AFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [3:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        prf_wr;
  logic [1:0]  prf_idx;
  logic [3:0]  prf_be;
  logic [31:0] prf_wdata, prf_rdata;

  logic [31:0] pmem [4];
  logic [31:0] exp_mem [4];
  logic [3:0]  exp_lock [4];
  logic        exp_hard;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #4 clk = ~clk;

  reg_softlock_unit #(.IDX_W(IDX_W), .GRAN(CFG)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .prf_wr(prf_wr), .prf_idx(prf_idx), .prf_be(prf_be),
    .prf_wdata(prf_wdata), .prf_rdata(prf_rdata)
  );

  assign prf_rdata = pmem[prf_idx];

  always @(posedge clk) begin
    if (prf_wr)
      for (int b = 0; b < 4; b++)
        if (prf_be[b]) pmem[prf_idx][8*b +: 8] <= prf_wdata[8*b +: 8];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected lock word from the granularity rules (R2..R5).
  function automatic logic [3:0] model_lock(input int w, input logic [3:0] cur,
                                            input logic [3:0] val, input logic [3:0] wen);
    logic [3:0] r;
    for (int l = 0; l < 4; l++) begin
      case (CFG[8*w + 2*l +: 2])
        2'b00: r[l] = 1'b0;
        2'b01: r[l] = wen[l] ? val[l] : cur[l];
        2'b10: begin
          if (l < 2) r[l] = wen[0] ? val[0] : cur[l];
          else       r[l] = wen[2] ? val[2] : cur[l];
        end
        default: r[l] = wen[0] ? val[0] : cur[l];
      endcase
    end
    return r;
  endfunction

  task automatic txn(input bit wr, input logic [1:0] rgn, input int idx,
                     input logic [3:0] be, input logic [31:0] wd, input string tag);
    logic [3:0]  cur;
    logic [3:0]  e_pbe;
    logic        e_err;
    logic [31:0] e_rd;
    cur   = exp_lock[idx];
    e_pbe = 4'b0;
    e_err = 1'b0;
    e_rd  = 32'b0;
    if (wr && (rgn == 2'd0 || rgn == 2'd1)) begin
      e_pbe = be & ~cur;
      e_err = |(be & cur);
    end else if (wr && rgn == 2'd2) begin
      e_err = exp_hard;
    end else if (!wr) begin
      case (rgn)
        2'd0, 2'd1: e_rd = exp_mem[idx];
        2'd2:       e_rd = {28'b0, cur};
        default:    e_rd = {31'b0, exp_hard};
      endcase
    end
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = {rgn, 2'(idx)};
    bus_be = be; bus_wdata = wd;
    #1;
    chk(prf_be == e_pbe && prf_wr == (|e_pbe), {tag, " byte filter"}, {27'b0, prf_wr, prf_be}, {27'b0, |e_pbe, e_pbe});
    @(posedge clk);
    #1;
    chk(rsp_valid && rsp_err == e_err, {tag, " response/error"}, {30'b0, rsp_valid, rsp_err}, {30'b0, 1'b1, e_err});
    if (!wr) chk(rsp_rdata == e_rd, {tag, " read data"}, rsp_rdata, e_rd);
    if (wr && (rgn == 2'd0 || rgn == 2'd1))
      for (int b = 0; b < 4; b++)
        if (e_pbe[b]) exp_mem[idx][8*b +: 8] = wd[8*b +: 8];
    if (wr && rgn == 2'd1 && !exp_hard) exp_lock[idx] = model_lock(idx, cur, 4'hF, be);
    if (wr && rgn == 2'd2 && !exp_hard) exp_lock[idx] = model_lock(idx, cur, wd[3:0], wd[7:4]);
    if (wr && rgn == 2'd3 && wd[0]) exp_hard = 1'b1;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    bus_req = 1'b0;
    @(posedge clk);
    #1;
    chk(!rsp_valid, tag, {31'b0, rsp_valid}, 32'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240607);
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    for (int w = 0; w < 4; w++) begin
      pmem[w] = 32'h1111_1111 * (w + 1);
      exp_mem[w] = 32'h1111_1111 * (w + 1);
      exp_lock[w] = 4'b0;
    end
    exp_hard = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp_valid, "R1 no response in reset", {31'b0, rsp_valid}, 32'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    for (int w = 0; w < 4; w++) txn(1'b0, 2'd2, w, 4'h0, 32'h0, "R1 lock reset");
    txn(1'b0, 2'd3, 0, 4'h0, 32'h0, "R1 hard lock reset");

    // R3: word 0 is 32-bit
    txn(1'b1, 2'd2, 0, 4'h0, 32'h0000_0011, "R3 lane0 locks word");
    txn(1'b0, 2'd2, 0, 4'h0, 32'h0, "R3 lock readback");
    txn(1'b1, 2'd2, 0, 4'h0, 32'h0000_00E0, "R3 upper lanes ignored");
    txn(1'b0, 2'd2, 0, 4'h0, 32'h0, "R3 lock readback");
    txn(1'b1, 2'd2, 0, 4'h0, 32'h0000_0010, "R3 unlock");

    // R4: word 3 is 16-bit pairs
    txn(1'b1, 2'd2, 3, 4'h0, 32'h0000_0011, "R4 lower half");
    txn(1'b1, 2'd2, 3, 4'h0, 32'h0000_0020, "R4 upper lane ignored");
    txn(1'b0, 2'd2, 3, 4'h0, 32'h0, "R4 lock readback");
    txn(1'b1, 2'd2, 3, 4'h0, 32'h0000_0044, "R4 upper half");
    txn(1'b0, 2'd2, 3, 4'h0, 32'h0, "R4 lock readback");

    // R5/R6: word 1 mixed, lane 2 unprotected
    txn(1'b1, 2'd2, 1, 4'h0, 32'hFFFF_FFFF, "R5 mixed word");
    txn(1'b0, 2'd2, 1, 4'h0, 32'h0, "R6 lock read layout");

    // R2: word 2 is 8-bit
    txn(1'b1, 2'd2, 2, 4'h0, 32'h0000_0022, "R2 single lane");
    txn(1'b1, 2'd2, 2, 4'h0, 32'h0000_0050, "R2 other lanes only");
    txn(1'b1, 2'd2, 2, 4'h0, 32'h0000_000F, "R2 no enables");
    txn(1'b0, 2'd2, 2, 4'h0, 32'h0, "R2 lock readback");

    // R7: blocked byte, others pass
    txn(1'b1, 2'd0, 2, 4'hF, 32'hDEAD_BEEF, "R7 partial block");
    txn(1'b0, 2'd0, 2, 4'h0, 32'h0, "R7 data readback");
    txn(1'b1, 2'd0, 0, 4'h6, 32'hCAFE_F00D, "R7 unlocked word");

    // R8: lock after write through mirror window
    txn(1'b1, 2'd1, 0, 4'h1, 32'h0000_00A5, "R8 mirror word");
    txn(1'b0, 2'd2, 0, 4'h0, 32'h0, "R8 lock readback");
    txn(1'b1, 2'd2, 3, 4'h0, 32'h0000_0050, "R8 unlock pair");
    txn(1'b1, 2'd1, 3, 4'h4, 32'h00BB_0000, "R8 mirror half");
    txn(1'b0, 2'd2, 3, 4'h0, 32'h0, "R8 lock readback");
    txn(1'b1, 2'd1, 3, 4'hF, 32'h1234_5678, "R8 mirror partly locked");

    // R10: both windows read the same word
    txn(1'b0, 2'd0, 1, 4'h0, 32'h0, "R10 normal read");
    txn(1'b0, 2'd1, 1, 4'h0, 32'h0, "R10 mirror read");
    txn(1'b0, 2'd1, 3, 4'h0, 32'h0, "R10 mirror read");

    // R11
    idle("R11 no request no response");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  rgn;
      bit          wr;
      int          idx;
      logic [3:0]  be;
      logic [31:0] wd;
      rgn = 2'($urandom_range(0, 2));
      wr  = 1'($urandom_range(0, 1));
      idx = $urandom_range(0, 3);
      be  = 4'($urandom);
      wd  = $urandom;
      if (!wr)            txn(wr, rgn, idx, be, wd, "R10 random read");
      else if (rgn == 0)  txn(wr, rgn, idx, be, wd, "R7 random write");
      else if (rgn == 1)  txn(wr, rgn, idx, be, wd, "R8 random mirror");
      else                txn(wr, rgn, idx, be, wd, "R2 random lock write");
      if (n % 50 == 0) idle("R11 random idle");
    end
    for (int w = 0; w < 4; w++) txn(1'b0, 2'd2, w, 4'h0, 32'h0, "R5 random lock readback");

    // R9: hard lock
    txn(1'b1, 2'd2, 2, 4'h0, 32'h0000_00F0, "R9 clear before hard lock");
    txn(1'b1, 2'd3, 0, 4'h0, 32'h0000_0001, "R9 set hard lock");
    txn(1'b0, 2'd3, 0, 4'h0, 32'h0, "R9 hard lock read");
    txn(1'b1, 2'd2, 2, 4'h0, 32'h0000_00FF, "R9 lock write refused");
    txn(1'b0, 2'd2, 2, 4'h0, 32'h0, "R9 lock unchanged");
    txn(1'b1, 2'd1, 2, 4'hF, 32'h5555_AAAA, "R9 mirror no lock");
    txn(1'b0, 2'd2, 2, 4'h0, 32'h0, "R9 lock unchanged");
    txn(1'b0, 2'd0, 2, 4'h0, 32'h0, "R9 data written");
    txn(1'b1, 2'd3, 0, 4'h0, 32'h0000_0000, "R9 clear attempt");
    txn(1'b0, 2'd3, 0, 4'h0, 32'h0, "R9 hard lock sticky");
    idle("R11 final idle");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule